// File: doc/BRIEF.md
# Exit-Point Profiling Counter Cache

This block counts how often each exit of a translated code group is taken. Every exit event presents the exit-point address of the group. The address is looked up in a tagged, set-associative table of counters. On a hit, the counter of the matching entry goes up by one. On a miss, an entry is allocated and its count starts at one. No profiling instructions are needed in the translated code, because the counting happens in hardware on every exit.

A monitor reads counts back through a separate read port. It presents an exit address and can optionally ask for the entry to be cleared as it is read. One cycle after the read is accepted, the block returns a hit flag and the stored count. Monitoring software uses these counts to decide when a group is worth re-optimizing.

The geometry is set by parameters: address width, number of sets, ways per set, counter width, and whether counters saturate or wrap. A large production configuration, such as 1024 sets of 8 ways for 8K entries, is selected by parameter. The default geometry is kept smaller.

Top module: `exitprof_table`

## Requirements
- R1: An address selects set `addr[2 +: log2(SETS)]`, and the bits above that set field form the tag. Address bits 1:0 are ignored, so the addresses X and X|3 count into the same entry. Two addresses with the same set field but different tags count separately.
- R2: An exit event whose address hits a valid entry increments that entry's count by exactly one in the following cycle.
- R3: An exit event that misses allocates the lowest-numbered invalid way of its set, if one exists, and starts the count at 1. Entries already in the set keep their counts.
- R4: When an exit event misses in a full set, the least-recently-used way is replaced. Only exit events update recency. Reads do not.
- R5: With the default saturating policy, a count that has reached 2^CNT_W-1 stays there on further exits.
- R6: A read is accepted in a cycle where `rd_req` and `rd_ready` are both high. In the next cycle `rd_ack` is 1, and `rd_hit` and `rd_count` carry the hit flag and the count. On a miss the count is 0.
- R7: An accepted read with `rd_clear` set that hits returns the old count and then sets the entry's count to 0. The entry stays valid, so a later read hits with count 0.
- R8: When an exit event and a read address the same set in the same cycle, `rd_ready` is 0, so the exit event is applied first and the read waits. A read to a different set is accepted in that same cycle.
- R9: A synchronous reset invalidates every entry and drives `rd_ack` to 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exit_valid | input | 1 | A group exit was taken this cycle |
| exit_addr | input | ADDR_W | Exit-point address of the taken exit |
| rd_req | input | 1 | Monitor read request |
| rd_addr | input | ADDR_W | Exit address to read |
| rd_clear | input | 1 | Clear the entry's count when the read hits |
| rd_ready | output | 1 | The read can be accepted this cycle |
| rd_ack | output | 1 | Read result valid (one cycle after acceptance) |
| rd_hit | output | 1 | The read address was present |
| rd_count | output | CNT_W | Count of the entry, or 0 on a miss |

## Verification
The bench drives the following patterns:

- **Repeated exits to one address, plus a low-bit alias.** These show incrementing and address folding. A differing tag in the same set shows that tags really separate entries.
- **A set filled one way at a time, then overfilled after re-touching its oldest entry.** This tells invalid-first allocation apart from LRU eviction, and LRU apart from FIFO.
- **A long run of exits on one address.** This separates saturation from wrap-around.
- **Same-cycle exit-and-read pairs, aimed at the same set and at different sets.** These show that the stall applies only to a real set collision, and that the stalled read sees the increment.

// File: rtl/exitprof_pkg.sv
package exitprof_pkg;
   // Counter update policy once the counter reaches its maximum value.
   typedef enum logic {CNT_WRAP = 1'b0, CNT_SATURATE = 1'b1} cnt_mode_e;
   localparam int unsigned ADDR_LSB = 2;
endpackage

// File: rtl/exitprof_lookup.sv
module exitprof_lookup #(
   parameter int WAYS  = 8,
   parameter int TAG_W = 23,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
   input  logic [WAYS-1:0]            vld_i,
   input  logic [TAG_W-1:0]           tag_i,
   output logic                       hit_o,
   output logic [WAY_W-1:0]           hit_way_o,
   output logic                       free_o,
   output logic [WAY_W-1:0]           free_way_o
);
   always_comb begin
      hit_o      = 1'b0;
      hit_way_o  = '0;
      free_o     = 1'b0;
      free_way_o = '0;
      // Walk downward so the lowest-numbered way wins.
      for (int w = WAYS-1; w >= 0; w--) begin
         if (vld_i[w] && tags_i[w] == tag_i) begin
            hit_o     = 1'b1;
            hit_way_o = WAY_W'(w);
         end
         if (!vld_i[w]) begin
            free_o     = 1'b1;
            free_way_o = WAY_W'(w);
         end
      end
   end
endmodule

// File: rtl/exitprof_lru.sv
module exitprof_lru #(
   parameter int WAYS = 8,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0][WAY_W-1:0] age_i,
   input  logic [WAY_W-1:0]           touch_i,
   output logic [WAYS-1:0][WAY_W-1:0] age_o,
   output logic [WAY_W-1:0]           victim_o
);
   // Ages form a permutation of 0..WAYS-1; 0 is the newest.
   always_comb begin
      victim_o = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (WAY_W'(w) == touch_i)
            age_o[w] = '0;
         else if (age_i[w] < age_i[touch_i])
            age_o[w] = age_i[w] + 1'b1;
         else
            age_o[w] = age_i[w];
         if (age_i[w] == WAY_W'(WAYS-1))
            victim_o = WAY_W'(w);
      end
   end
endmodule

// File: rtl/exitprof_table.sv
module exitprof_table
   import exitprof_pkg::*;
#(
   parameter int        ADDR_W = 32,
   parameter int        SETS   = 128,
   parameter int        WAYS   = 8,
   parameter int        CNT_W  = 16,
   parameter cnt_mode_e MODE   = CNT_SATURATE
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              exit_valid,
   input  logic [ADDR_W-1:0] exit_addr,
   input  logic              rd_req,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_clear,
   output logic              rd_ready,
   output logic              rd_ack,
   output logic              rd_hit,
   output logic [CNT_W-1:0]  rd_count
);
   localparam int IDX_W = $clog2(SETS);
   localparam int WAY_W = $clog2(WAYS);
   localparam int LSB   = int'(ADDR_LSB);
   localparam int TAG_W = ADDR_W - LSB - IDX_W;

   // Elaboration-time parameter checks
   if (SETS < 2 || SETS != (1 << IDX_W)) begin : g_bad_sets
      $error("SETS must be a power of two, at least 2");
   end
   if (WAYS < 2 || WAYS != (1 << WAY_W)) begin : g_bad_ways
      $error("WAYS must be a power of two, at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("ADDR_W too small for the chosen SETS");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must be at least 2");
   end

   // Storage
   logic [SETS-1:0][WAYS-1:0]     vld_q;
   logic [WAYS-1:0][TAG_W-1:0]    tag_q [SETS];
   logic [WAYS-1:0][CNT_W-1:0]    cnt_q [SETS];
   logic [WAYS-1:0][WAY_W-1:0]    age_q [SETS];

   // Address split
   logic [IDX_W-1:0] ex_idx, rd_idx;
   logic [TAG_W-1:0] ex_tag, rd_tag;
   logic [3:0]       unused_low;
   assign ex_idx     = exit_addr[LSB +: IDX_W];
   assign rd_idx     = rd_addr[LSB +: IDX_W];
   assign ex_tag     = exit_addr[ADDR_W-1 -: TAG_W];
   assign rd_tag     = rd_addr[ADDR_W-1 -: TAG_W];
   assign unused_low = {exit_addr[1:0], rd_addr[1:0]};

   // Exit-side lookup
   logic             ex_hit, ex_free;
   logic [WAY_W-1:0] ex_hit_way, ex_free_way, ex_victim, ex_way;
   logic [WAYS-1:0][WAY_W-1:0] age_nxt;

   exitprof_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_ex_look (
      .tags_i     (tag_q[ex_idx]),
      .vld_i      (vld_q[ex_idx]),
      .tag_i      (ex_tag),
      .hit_o      (ex_hit),
      .hit_way_o  (ex_hit_way),
      .free_o     (ex_free),
      .free_way_o (ex_free_way)
   );

   exitprof_lru #(.WAYS(WAYS)) u_lru (
      .age_i    (age_q[ex_idx]),
      .touch_i  (ex_way),
      .age_o    (age_nxt),
      .victim_o (ex_victim)
   );

   assign ex_way = ex_hit ? ex_hit_way : (ex_free ? ex_free_way : ex_victim);

   // Read-side lookup
   logic             rd_hit_c;
   logic [WAY_W-1:0] rd_way;
   logic             unused_rd_free;
   logic [WAY_W-1:0] unused_rd_free_way;

   exitprof_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_rd_look (
      .tags_i     (tag_q[rd_idx]),
      .vld_i      (vld_q[rd_idx]),
      .tag_i      (rd_tag),
      .hit_o      (rd_hit_c),
      .hit_way_o  (rd_way),
      .free_o     (unused_rd_free),
      .free_way_o (unused_rd_free_way)
   );

   // Counter update variant
   logic [CNT_W-1:0] cur_cnt, inc_cnt;
   assign cur_cnt = cnt_q[ex_idx][ex_hit_way];

   if (MODE == CNT_SATURATE) begin : g_sat
      assign inc_cnt = (&cur_cnt) ? cur_cnt : cur_cnt + 1'b1;
   end else begin : g_wrap
      assign inc_cnt = cur_cnt + 1'b1;
   end

   // Exit events win a same-set collision; the read waits.
   logic rd_fire;
   assign rd_ready = !(exit_valid && (rd_idx == ex_idx));
   assign rd_fire  = rd_req && rd_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < SETS; s++) begin
            vld_q[s] <= '0;
            for (int w = 0; w < WAYS; w++)
               age_q[s][w] <= WAY_W'(w);
         end
         rd_ack   <= 1'b0;
         rd_hit   <= 1'b0;
         rd_count <= '0;
      end else begin
         rd_ack   <= rd_fire;
         rd_hit   <= rd_fire && rd_hit_c;
         rd_count <= (rd_fire && rd_hit_c) ? cnt_q[rd_idx][rd_way] : '0;
         if (exit_valid) begin
            vld_q[ex_idx][ex_way] <= 1'b1;
            tag_q[ex_idx][ex_way] <= ex_tag;
            cnt_q[ex_idx][ex_way] <= ex_hit ? inc_cnt : CNT_W'(1);
            age_q[ex_idx]         <= age_nxt;
         end
         if (rd_fire && rd_clear && rd_hit_c)
            cnt_q[rd_idx][rd_way] <= '0;
      end
   end
endmodule

// File: rtl/exitprof_chk.sv
module exitprof_chk #(
   parameter int ADDR_W = 32,
   parameter int SETS   = 128,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              exit_valid,
   input logic [ADDR_W-1:0] exit_addr,
   input logic              rd_req,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              rd_ready,
   input logic              rd_ack,
   input logic              rd_hit,
   input logic [CNT_W-1:0]  rd_count
);
   localparam int IDX_W = $clog2(SETS);

   logic same_set;
   assign same_set = exit_addr[2 +: IDX_W] == rd_addr[2 +: IDX_W];

   // R6
   rd_ack_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_req && rd_ready) |=> rd_ack);

   // R6
   rd_ack_source_chk: assert property (@(posedge clk) disable iff (rst)
      (!rd_req || !rd_ready) |=> !rd_ack);

   // R6
   miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_ack && !rd_hit) |-> (rd_count == '0));

   // R8
   collide_stall_chk: assert property (@(posedge clk) disable iff (rst)
      (exit_valid && same_set) |-> !rd_ready);

   // R8
   apart_ready_chk: assert property (@(posedge clk) disable iff (rst)
      (!exit_valid || !same_set) |-> rd_ready);

   // R9
   reset_ack_chk: assert property (@(posedge clk)
      rst |=> !rd_ack);
endmodule

bind exitprof_table exitprof_chk #(.ADDR_W(ADDR_W), .SETS(SETS), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst(rst), .exit_valid(exit_valid), .exit_addr(exit_addr),
   .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_ack(rd_ack),
   .rd_hit(rd_hit), .rd_count(rd_count)
);

// File: tb/test_exitprof_table.sv
`timescale 1ns/1ps
module test_exitprof_table;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        exit_valid = 1'b0;
   logic [31:0] exit_addr = '0;
   logic        rd_req = 1'b0;
   logic [31:0] rd_addr = '0;
   logic        rd_clear = 1'b0;
   logic        rd_ready, rd_ack, rd_hit;
   logic [15:0] rd_count;

   int vectors = 0;
   int miscompares = 0;
   int cycles = 0;

   always #2 clk = ~clk;   // 250 MHz

   exitprof_table i_exitprof_table (
      .clk(clk), .rst(rst), .exit_valid(exit_valid), .exit_addr(exit_addr),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_clear(rd_clear),
      .rd_ready(rd_ready), .rd_ack(rd_ack), .rd_hit(rd_hit), .rd_count(rd_count)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         miscompares++;
         $display("FAIL watchdog: act=%0d exp=<150000 cycles", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   // Address with 23-bit tag, 7-bit set field at bit 2.
   function automatic logic [31:0] mk(input int tag, input int set);
      return {tag[22:0], set[6:0], 2'b00};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic do_exit(input logic [31:0] a, input int n);
      @(negedge clk);
      exit_valid = 1'b1;
      exit_addr  = a;
      repeat (n) @(negedge clk);
      exit_valid = 1'b0;
   endtask

   task automatic do_read(input logic [31:0] a, input logic clr,
                          output logic hit, output logic [15:0] cnt);
      @(negedge clk);
      rd_req = 1'b1; rd_addr = a; rd_clear = clr;
      #1;
      while (!rd_ready) begin
         @(negedge clk);
         #1;
      end
      @(negedge clk);
      rd_req = 1'b0; rd_clear = 1'b0;
      #1;
      chk("R6 ack", {31'd0, rd_ack}, 32'd1);
      hit = rd_hit;
      cnt = rd_count;
   endtask

   task automatic expect_read(input string req, input logic [31:0] a, input logic clr,
                              input logic ehit, input int ecnt);
      logic h;
      logic [15:0] c;
      do_read(a, clr, h, c);
      chk({req, " hit"}, {31'd0, h}, {31'd0, ehit});
      chk({req, " count"}, {16'd0, c}, ecnt[31:0]);
   endtask

   task automatic t_reset();
      #1;
      chk("R9 ack low after reset", {31'd0, rd_ack}, 32'd0);
      expect_read("R9 empty table", mk(5, 3), 1'b0, 1'b0, 0);
   endtask

   task automatic t_basic();
      do_exit(mk(1, 10), 3);
      expect_read("R2 three exits", mk(1, 10), 1'b0, 1'b1, 3);
      do_exit(mk(1, 10) | 32'd3, 1);
      expect_read("R1 low bits ignored", mk(1, 10), 1'b0, 1'b1, 4);
      expect_read("R1 other tag misses", mk(2, 10), 1'b0, 1'b0, 0);
      expect_read("R6 miss count zero", mk(1, 11), 1'b0, 1'b0, 0);
   endtask

   task automatic t_fill_lru();
      for (int t = 0; t < 8; t++) do_exit(mk(100 + t, 20), 1);
      for (int t = 0; t < 8; t++)
         expect_read("R3 fill keeps all", mk(100 + t, 20), 1'b0, 1'b1, 1);
      do_exit(mk(100, 20), 1);       // way of tag 100 becomes newest
      do_exit(mk(108, 20), 1);       // evicts tag 101
      expect_read("R4 LRU evicted", mk(101, 20), 1'b0, 1'b0, 0);
      expect_read("R4 refreshed kept", mk(100, 20), 1'b0, 1'b1, 2);
      expect_read("R4 new entry", mk(108, 20), 1'b0, 1'b1, 1);
      expect_read("R4 others kept", mk(102, 20), 1'b0, 1'b1, 1);
   endtask

   task automatic t_clear();
      do_exit(mk(7, 40), 5);
      expect_read("R7 clear returns old", mk(7, 40), 1'b1, 1'b1, 5);
      expect_read("R7 cleared stays valid", mk(7, 40), 1'b0, 1'b1, 0);
      do_exit(mk(7, 40), 1);
      expect_read("R7 counts after clear", mk(7, 40), 1'b0, 1'b1, 1);
   endtask

   task automatic t_collide();
      do_exit(mk(3, 50), 2);
      @(negedge clk);
      exit_valid = 1'b1; exit_addr = mk(3, 50);
      rd_req = 1'b1; rd_addr = mk(3, 50); rd_clear = 1'b0;
      #1;
      chk("R8 same set stalls", {31'd0, rd_ready}, 32'd0);
      @(negedge clk);
      exit_valid = 1'b0;
      #1;
      chk("R8 ready after exit", {31'd0, rd_ready}, 32'd1);
      @(negedge clk);
      rd_req = 1'b0;
      #1;
      chk("R8 ack after stall", {31'd0, rd_ack}, 32'd1);
      chk("R8 read sees increment", {16'd0, rd_count}, 32'd3);
      // different set in the same cycle is accepted
      @(negedge clk);
      exit_valid = 1'b1; exit_addr = mk(4, 51);
      rd_req = 1'b1; rd_addr = mk(3, 50);
      #1;
      chk("R8 other set ready", {31'd0, rd_ready}, 32'd1);
      @(negedge clk);
      exit_valid = 1'b0; rd_req = 1'b0;
      #1;
      chk("R8 other set count", {16'd0, rd_count}, 32'd3);
      expect_read("R8 exit applied", mk(4, 51), 1'b0, 1'b1, 1);
   endtask

   task automatic t_saturate();
      do_exit(mk(9, 60), 65534);
      expect_read("R5 below max", mk(9, 60), 1'b0, 1'b1, 65534);
      do_exit(mk(9, 60), 3);
      expect_read("R5 holds at max", mk(9, 60), 1'b0, 1'b1, 65535);
   endtask

   task automatic t_rerst();
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      #1;
      chk("R9 ack low", {31'd0, rd_ack}, 32'd0);
      expect_read("R9 entry invalidated", mk(1, 10), 1'b0, 1'b0, 0);
      expect_read("R9 set cleared", mk(100, 20), 1'b0, 1'b0, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_basic();
      t_fill_lru();
      t_clear();
      t_collide();
      t_saturate();
      t_rerst();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule